// File: doc/BRIEF.md
# Fault Latch and Bus Alert Generator

This block records six kinds of power-path fault events in sticky bits and turns them into a bus alert. Each enable bit lets one kind of fault pull the shared active-low alert line. The events are overvoltage, undervoltage, overcurrent, power bad, enable-pin toggle and shorted pass transistor. Raw condition levels arrive asynchronously. They are synchronized, and only the qualifying edge of each one latches its fault bit. Software reads the fault bits, and clears them by writing zeros.

The alert is serviced in one of two ways: the bus front end reports that the device answered an alert-response query, or it reports that the device was addressed for any transfer. At that point the block records which enabled faults were pending and releases the line. The line goes low again only for a fault bit that was not part of that record. Such a bit is either newly set, or was cleared and then set again. A condition that persists or repeats under an already-set bit stays silent.

A separate register bit drives the same pull-down directly, as a general-purpose output. It bypasses the alert logic.

Top module: `fault_alert_ctrl`

## Requirements
- R1: After reset, `fault_o`, `alert_en_o`, `alert_pull_o` and `ara_req_o` are all zero.
- R2: Each fault bit sets within four clock cycles of the qualifying edge of its condition input, and stays set after the condition goes away. The bits and their edges are:
  - bit 0: `cond_i[0]` rising
  - bit 1: `cond_i[1]` falling
  - bit 2: `cond_i[2]` rising
  - bit 3: `cond_i[3]` falling
  - bit 4: either edge of `cond_i[4]`
  - bit 5: `cond_i[5]` rising
- R3: A cycle with `alert_en_we_i` high loads `wr_data_i[5:0]` into `alert_en_o`. Enable bit n gates fault bit n.
- R4: A cycle with `fault_we_i` high loads `wr_data_i[6:0]` into `fault_o`. A 0 written to a bit clears it.
- R5: `ara_req_o` and `alert_pull_o` are high whenever an enabled fault bit is set and has not been serviced. A set fault bit whose enable is 0 raises neither of them.
- R6: A cycle with `ara_sent_i` high releases the alert from the next cycle on.
- R7: A cycle with `addressed_i` high releases the alert in the same way.
- R8: After release, the alert stays released for as long as the serviced fault bits stay set, even if their conditions make further qualifying edges.
- R9: After release, a different enabled fault bit that sets raises the alert again.
- R10: After release, a serviced bit that is cleared and then set again raises the alert again.
- R11: Fault bit 6 high drives `alert_pull_o` high without raising `ara_req_o`.
- R12: `ara_req_o` is low whenever no alert is pending, so the alert-response query is not answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | 6 | Raw condition levels, asynchronous |
| fault_we_i | input | 1 | Fault register write strobe |
| alert_en_we_i | input | 1 | Alert enable register write strobe |
| wr_data_i | input | 7 | Register write data |
| ara_sent_i | input | 1 | Front end answered the alert-response query |
| addressed_i | input | 1 | Front end saw this device addressed |
| fault_o | output | 7 | Fault register value (bit 6 is the direct pin drive) |
| alert_en_o | output | 6 | Alert enable register value |
| alert_pull_o | output | 1 | Pull-down on the alert pin (1 = pull low) |
| ara_req_o | output | 1 | Request to answer the alert-response query |

## Verification
The hardest state to reach is a serviced alert that must stay quiet while its fault condition bounces again. The bench must show that the fault bit stays set and the line stays released. It must then show that the same bit raises the line once software has cleared it and the condition returns.

The bench sweeps every fault bit, both with its enable set and with it cleared, through a fixed sequence:
1. Raise the condition.
2. Service the alert.
3. Toggle the condition again.
4. Clear the fault bit.
5. Raise the condition once more.
6. Service the alert again, by addressing the device.

Expected values come from the bit index and the enable under test.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int unsigned NUM_EVT = 6;
  localparam int unsigned PIN_BIT = NUM_EVT;
  localparam int unsigned REG_W   = NUM_EVT + 1;
  typedef logic [NUM_EVT-1:0] evt_vec_t;
  typedef logic [REG_W-1:0]   reg_vec_t;
endpackage

// File: rtl/fa_edge_event.sv
module fa_edge_event #(
  parameter int unsigned WIDTH       = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] FALL_MASK = '0,
  parameter logic [WIDTH-1:0] BOTH_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] evt_o
);
  localparam int unsigned PRIME_W = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0][WIDTH-1:0] sync_q;
  logic [WIDTH-1:0]   prev_q;
  logic [PRIME_W-1:0] prime_q;
  logic [WIDTH-1:0]   cur;
  logic               primed;

  assign cur    = sync_q[SYNC_STAGES-1];
  assign primed = prime_q[PRIME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      prev_q  <= '0;
      prime_q <= '0;
    end else begin
      sync_q[0] <= level_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q  <= cur;
      prime_q <= {prime_q[PRIME_W-2:0], 1'b1};
    end
  end

  // edge qualification selected per bit; suppressed until the pipeline holds real samples
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic rise, fall;
    assign rise = cur[b] & ~prev_q[b];
    assign fall = ~cur[b] & prev_q[b];
    if (BOTH_MASK[b]) begin : g_both
      assign evt_o[b] = primed & (rise | fall);
    end else if (FALL_MASK[b]) begin : g_fall
      assign evt_o[b] = primed & fall;
    end else begin : g_rise
      assign evt_o[b] = primed & rise;
    end
  end
endmodule

// File: rtl/fa_fault_regs.sv
module fa_fault_regs
  import fa_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  evt_vec_t set_i,
  input  logic     fault_we_i,
  input  logic     alert_en_we_i,
  input  reg_vec_t wr_data_i,
  output reg_vec_t fault_o,
  output evt_vec_t alert_en_o
);
  reg_vec_t fault_q;
  evt_vec_t en_q;
  reg_vec_t fault_base;

  assign fault_base = fault_we_i ? wr_data_i : fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= '0;
      en_q    <= '0;
    end else begin
      // a set event in the write cycle survives the write
      fault_q <= fault_base | {1'b0, set_i};
      if (alert_en_we_i) en_q <= wr_data_i[NUM_EVT-1:0];
    end
  end

  assign fault_o    = fault_q;
  assign alert_en_o = en_q;
endmodule

// File: rtl/fa_alert_track.sv
module fa_alert_track
  import fa_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  evt_vec_t fault_i,
  input  evt_vec_t en_i,
  input  logic     release_i,
  output logic     alert_o
);
  evt_vec_t snap_q;
  evt_vec_t enabled;

  assign enabled = fault_i & en_i;
  assign alert_o = |(enabled & ~snap_q);

  // snapshot of serviced faults; a bit drops once its fault bit is cleared
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (release_i) snap_q <= enabled;
    else                snap_q <= snap_q & fault_i;
  end
endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
  import fa_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NUM_EVT-1:0] FALL_MASK = 6'b001010,
  parameter logic [NUM_EVT-1:0] BOTH_MASK = 6'b010000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] cond_i,
  input  logic               fault_we_i,
  input  logic               alert_en_we_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic               ara_sent_i,
  input  logic               addressed_i,
  output logic [REG_W-1:0]   fault_o,
  output logic [NUM_EVT-1:0] alert_en_o,
  output logic               alert_pull_o,
  output logic               ara_req_o
);
  evt_vec_t set_evt;
  reg_vec_t fault_q;
  evt_vec_t en_q;
  logic     alert;

  fa_edge_event #(
    .WIDTH      (NUM_EVT),
    .SYNC_STAGES(SYNC_STAGES),
    .FALL_MASK  (FALL_MASK),
    .BOTH_MASK  (BOTH_MASK)
  ) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(cond_i),
    .evt_o  (set_evt)
  );

  fa_fault_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set_evt),
    .fault_we_i   (fault_we_i),
    .alert_en_we_i(alert_en_we_i),
    .wr_data_i    (wr_data_i),
    .fault_o      (fault_q),
    .alert_en_o   (en_q)
  );

  fa_alert_track u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fault_i  (fault_q[NUM_EVT-1:0]),
    .en_i     (en_q),
    .release_i(ara_sent_i | addressed_i),
    .alert_o  (alert)
  );

  assign fault_o      = fault_q;
  assign alert_en_o   = en_q;
  assign ara_req_o    = alert;
  assign alert_pull_o = alert | fault_q[PIN_BIT];
endmodule

// File: rtl/fault_alert_ctrl_chk.sv
module fault_alert_ctrl_chk
  import fa_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] cond_i,
  input logic               fault_we_i,
  input logic               alert_en_we_i,
  input logic [REG_W-1:0]   wr_data_i,
  input logic               ara_sent_i,
  input logic               addressed_i,
  input logic [REG_W-1:0]   fault_o,
  input logic [NUM_EVT-1:0] alert_en_o,
  input logic               alert_pull_o,
  input logic               ara_req_o
);
  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_we_i |=> ((fault_o & $past(fault_o)) == $past(fault_o)));

  p_en_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_en_we_i |=> (alert_en_o == $past(wr_data_i[NUM_EVT-1:0])));

  p_req_pulls_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ara_req_o |-> alert_pull_o);

  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ara_sent_i || addressed_i) |=>
      (!ara_req_o || fault_o != $past(fault_o) || alert_en_o != $past(alert_en_o)));

  p_no_retrigger_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ara_req_o) |-> (fault_o != $past(fault_o) || alert_en_o != $past(alert_en_o)));

  p_pin_pull_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o[PIN_BIT] |-> alert_pull_o);

  p_pull_source_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_pull_o |-> (ara_req_o || fault_o[PIN_BIT]));

  p_req_needs_fault_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ara_req_o |-> ((fault_o[NUM_EVT-1:0] & alert_en_o) != '0));
endmodule

bind fault_alert_ctrl fault_alert_ctrl_chk u_chk (.*);

// File: tb/fault_alert_ctrl_test.sv
module fault_alert_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] IDLE = 6'b001010;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cond = IDLE;
  logic       fault_we = 1'b0, en_we = 1'b0, ara_sent = 1'b0, addressed = 1'b0;
  logic [6:0] wdata = '0;
  logic [6:0] fault_o;
  logic [5:0] alert_en_o;
  logic       alert_pull, ara_req;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_alert_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond),
    .fault_we_i(fault_we), .alert_en_we_i(en_we), .wr_data_i(wdata),
    .ara_sent_i(ara_sent), .addressed_i(addressed),
    .fault_o(fault_o), .alert_en_o(alert_en_o),
    .alert_pull_o(alert_pull), .ara_req_o(ara_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_fault(input logic [6:0] d);
    wdata = d; fault_we = 1'b1; cycles(1); fault_we = 1'b0;
  endtask

  task automatic wr_en(input logic [6:0] d);
    wdata = d; en_we = 1'b1; cycles(1); en_we = 1'b0;
  endtask

  task automatic pulse_ara();
    ara_sent = 1'b1; cycles(1); ara_sent = 1'b0;
  endtask

  task automatic pulse_addr();
    addressed = 1'b1; cycles(1); addressed = 1'b0;
  endtask

  task automatic toggle(input int i);
    cond[i] = ~cond[i]; cycles(4);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cycles(3);
    check("R1 fault", fault_o, 0);
    check("R1 en", alert_en_o, 0);
    check("R1 pull", alert_pull, 0);
    check("R1 req", ara_req, 0);
    rst_n = 1'b1;
    cycles(5);
    check("R1 idle after reset", {fault_o, ara_req}, 0);

    wr_en(7'h2A);
    check("R3 enable load", alert_en_o, 6'h2A);
    wr_en(7'h7F);
    check("R3 enable width", alert_en_o, 6'h3F);
    wr_fault(7'h7F);
    check("R4 fault write", fault_o, 7'h7F);
    wr_fault(7'h00);
    check("R4 fault clear", fault_o, 7'h00);
    cycles(1);

    for (int i = 0; i < 6; i++) begin
      for (int en = 0; en < 2; en++) begin
        logic [5:0] bitm;
        bitm = 6'(1 << i);
        wr_en({1'b0, en ? bitm : 6'h00});
        wr_fault(7'h00);
        cycles(1);
        toggle(i);
        check($sformatf("R2 set bit%0d", i), fault_o, {1'b0, bitm});
        check($sformatf("R5 req bit%0d en%0d", i, en), ara_req, en);
        check($sformatf("R5 pull bit%0d en%0d", i, en), alert_pull, en);
        toggle(i);
        check($sformatf("R2 sticky bit%0d", i), fault_o, {1'b0, bitm});
        if (en == 0) begin
          check($sformatf("R12 no req bit%0d", i), ara_req, 0);
        end else begin
          pulse_ara();
          check($sformatf("R6 release bit%0d", i), ara_req, 0);
          toggle(i); toggle(i);
          check($sformatf("R8 no retrigger bit%0d", i), ara_req, 0);
          check($sformatf("R8 still set bit%0d", i), fault_o, {1'b0, bitm});
          wr_fault(7'h00);
          check($sformatf("R4 clear bit%0d", i), fault_o, 0);
          cycles(2);
          toggle(i);
          check($sformatf("R10 retrigger bit%0d", i), ara_req, 1);
          pulse_addr();
          check($sformatf("R7 addr release bit%0d", i), ara_req, 0);
          check($sformatf("R7 pull released bit%0d", i), alert_pull, 0);
          toggle(i);
        end
        wr_fault(7'h00);
        cycles(2);
      end
    end

    // different bit after service
    wr_en(7'h3F);
    wr_fault(7'h00);
    cycles(2);
    toggle(0);
    check("R5 req bit0", ara_req, 1);
    pulse_ara();
    check("R6 release multi", ara_req, 0);
    toggle(2);
    check("R9 new bit retriggers", ara_req, 1);
    check("R9 both bits", fault_o, 7'h05);
    pulse_ara();
    check("R6 release again", ara_req, 0);
    toggle(0); toggle(2);

    // direct pin drive
    wr_en(7'h00);
    wr_fault(7'h40);
    check("R11 pin pull", alert_pull, 1);
    check("R11 no req", ara_req, 0);
    wr_fault(7'h00);
    check("R11 pin released", alert_pull, 0);
    check("R12 idle req", ara_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule